// File: doc/BRIEF.md
# Second-Order Velocity Loop Filter

This block is the loop filter of a carrier tracking loop that locks on velocity instead of frequency. Once per loop update period, which is also the coherent integration period, the discriminator presents one signed velocity-error sample with a strobe. The filter scales that sample by two fixed-point gains and feeds two cascaded saturating integrators. The first gain is the square of the characteristic angular frequency times the update interval. The second gain is the damping-related gain times the angular frequency.

Three estimates leave the block. The jerk estimate is the signal entering the first integrator. The acceleration estimate is the signal entering the second integrator. The filtered velocity is the output of the second integrator. The velocity is held for the whole period and serves as the velocity prediction for the start of the next period. A downstream oscillator uses all three values to compensate phase sample by sample within the period. Both gains arrive pre-scaled, with FRAC_BITS fractional bits.

Top module: `vel_loop_filter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both integrator states, all three estimates and est_valid to zero on that edge.
- R2: In a cycle without err_valid, the three estimates and the integrator states keep their values, whatever err_sample, k_jerk and k_accel do.
- R3: On a strobe, jerk_est becomes floor((err_sample * k_jerk) / 2^FRAC_BITS), sign-extended to 32 bits, with FRAC_BITS = 8 by default.
- R4: On a strobe, the first integrator state becomes sat(state + jerk term). accel_est becomes sat(new first state + floor((err_sample * k_accel) / 2^FRAC_BITS)).
- R5: On a strobe, vel_est becomes sat(previous vel_est + new accel_est). vel_est is the second integrator state.
- R6: All three estimates update on the clock edge that samples err_valid high. est_valid is high for exactly the following cycle and is low after any cycle without a strobe.
- R7: Every integrator sum saturates to the signed 32-bit limits, +2147483647 and -2147483648, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | One-cycle strobe for a new velocity-error sample |
| err_sample | input | 16 | Signed velocity error from the discriminator |
| k_jerk | input | 16 | Signed gain ω0²·T, FRAC_BITS fractional bits |
| k_accel | input | 16 | Signed gain a·ω0, FRAC_BITS fractional bits |
| jerk_est | output | 32 | Signed jerk estimate (input of the first integrator) |
| accel_est | output | 32 | Signed acceleration estimate (input of the second integrator) |
| vel_est | output | 32 | Signed filtered velocity, held between strobes |
| est_valid | output | 1 | High for one cycle when the estimates have updated |

## Verification
Directed strobes test the filter first. A zero error must leave the states unchanged. Single positive and negative errors separate the sign handling of the floor shift from a truncating shift. A long run of random errors and gains with gaps between strobes checks that the two integrators chain in the right order, with the new first state feeding the acceleration. Gain and error changes between strobes must not move the outputs. Runs of full-scale errors of each sign drive both integrators into their limits, which separates saturation from wraparound. A reset in the middle of a run must clear everything.

// File: rtl/velf_pkg.sv
package velf_pkg;
    localparam int STATE_W = 32;

    typedef logic signed [STATE_W-1:0] velf_word_t;

    typedef struct packed {
        velf_word_t s1;
        velf_word_t jerk;
        velf_word_t acc;
        velf_word_t vel;
        logic       vld;
    } velf_state_t;
endpackage

// File: rtl/velf_gain_scale.sv
module velf_gain_scale #(
    parameter int IN_W   = 16,
    parameter int COEF_W = 16,
    parameter int OUT_W  = 32,
    parameter int FRAC   = 8
) (
    input  logic signed [IN_W-1:0]   sample_i,
    input  logic signed [COEF_W-1:0] coef_i,
    output logic signed [OUT_W-1:0]  scaled_o
);
    // Full product needs IN_W + COEF_W bits; OUT_W must be at least that.
    logic signed [OUT_W-1:0] prod;

    always_comb begin
        prod     = OUT_W'(sample_i) * OUT_W'(coef_i);
        scaled_o = prod >>> FRAC;   // arithmetic shift: floor division
    end
endmodule

// File: rtl/velf_sat_add.sv
module velf_sat_add #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] sum_o
);
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    always_comb begin
        wide = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        if (wide[W] != wide[W-1]) begin
            sum_o = wide[W] ? MIN_V : MAX_V;
        end else begin
            sum_o = wide[W-1:0];
        end
    end
endmodule

// File: rtl/vel_loop_filter.sv
module vel_loop_filter
    import velf_pkg::*;
#(
    parameter int ERR_W     = 16,
    parameter int COEF_W    = 16,
    parameter int FRAC_BITS = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      err_valid,
    input  logic signed [ERR_W-1:0]   err_sample,
    input  logic signed [COEF_W-1:0]  k_jerk,
    input  logic signed [COEF_W-1:0]  k_accel,
    output logic signed [STATE_W-1:0] jerk_est,
    output logic signed [STATE_W-1:0] accel_est,
    output logic signed [STATE_W-1:0] vel_est,
    output logic                      est_valid
);
    localparam int W = STATE_W;

    velf_state_t st_d, st_q;
    velf_word_t  jerk_term, prop_term, s1_sum, acc_sum, vel_sum;

    // Gain stages
    velf_gain_scale #(.IN_W(ERR_W), .COEF_W(COEF_W), .OUT_W(W), .FRAC(FRAC_BITS))
        u_jerk_gain (.sample_i(err_sample), .coef_i(k_jerk), .scaled_o(jerk_term));
    velf_gain_scale #(.IN_W(ERR_W), .COEF_W(COEF_W), .OUT_W(W), .FRAC(FRAC_BITS))
        u_prop_gain (.sample_i(err_sample), .coef_i(k_accel), .scaled_o(prop_term));

    // First integrator, acceleration sum, second integrator
    velf_sat_add #(.W(W)) u_integ1 (.a_i(st_q.s1),  .b_i(jerk_term), .sum_o(s1_sum));
    velf_sat_add #(.W(W)) u_accsum (.a_i(s1_sum),   .b_i(prop_term), .sum_o(acc_sum));
    velf_sat_add #(.W(W)) u_integ2 (.a_i(st_q.vel), .b_i(acc_sum),   .sum_o(vel_sum));

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (err_valid) begin
            st_d.jerk = jerk_term;
            st_d.s1   = s1_sum;
            st_d.acc  = acc_sum;
            st_d.vel  = vel_sum;
            st_d.vld  = 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign jerk_est  = st_q.jerk;
    assign accel_est = st_q.acc;
    assign vel_est   = st_q.vel;
    assign est_valid = st_q.vld;

    // Reset clears outputs (R1)
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (vel_est == '0 && accel_est == '0 && jerk_est == '0 && !est_valid));

    // Outputs hold without a strobe (R2)
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !err_valid |=> ($stable(vel_est) && $stable(accel_est) && $stable(jerk_est)));

    // Valid pulse timing (R6)
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> est_valid);
    assert_valid_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !err_valid |=> !est_valid);

    // Velocity moves in the direction of the added term, never wraps (R7)
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (err_valid && !acc_sum[W-1]) |=> (vel_est >= $past(vel_est)));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (err_valid && acc_sum[W-1]) |=> (vel_est <= $past(vel_est)));
endmodule

// File: tb/vel_loop_filter_bench.sv
module vel_loop_filter_bench;
    localparam int FRAC = 8;
    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic err_valid = 1'b0;
    logic signed [15:0] err_sample = '0, k_jerk = '0, k_accel = '0;
    logic signed [31:0] jerk_est, accel_est, vel_est;
    logic est_valid;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    longint m_s1 = 0, m_jerk = 0, m_acc = 0, m_vel = 0;

    always #5 clk = ~clk;

    vel_loop_filter u_vel_loop_filter (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_sample(err_sample),
        .k_jerk(k_jerk), .k_accel(k_accel), .jerk_est(jerk_est),
        .accel_est(accel_est), .vel_est(vel_est), .est_valid(est_valid));

    function automatic longint sat(input longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    function automatic longint scale(input longint e, input longint k);
        return (e * k) >>> FRAC;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " jerk"}, jerk_est, m_jerk);
        check({req, " accel"}, accel_est, m_acc);
        check({req, " vel"}, vel_est, m_vel);
    endtask

    // Strobe one sample; check one clock later (R3, R4, R5, R6)
    task automatic strobe(input logic signed [15:0] e, input logic signed [15:0] kj,
                          input logic signed [15:0] ka);
        err_sample = e; k_jerk = kj; k_accel = ka; err_valid = 1'b1;
        m_jerk = scale(e, kj);
        m_s1   = sat(m_s1 + m_jerk);
        m_acc  = sat(m_s1 + scale(e, ka));
        m_vel  = sat(m_vel + m_acc);
        @(negedge clk);
        err_valid = 1'b0;
        check("R6 valid", est_valid, 1);
        check_all("R3/R4/R5");
    endtask

    task automatic idle_check;
        err_sample = 16'sh7abc; k_jerk = 16'sh1234; k_accel = -16'sh4321;
        @(negedge clk);
        check("R6 idle", est_valid, 0);
        check_all("R2 hold");
    endtask

    task automatic do_reset;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_s1 = 0; m_jerk = 0; m_acc = 0; m_vel = 0;
        check("R1 valid", est_valid, 0);
        check_all("R1 reset");
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();
        // Directed cases
        strobe(16'sd0, 16'sd300, 16'sd500);
        strobe(16'sd1000, 16'sd256, 16'sd512);
        idle_check();
        strobe(-16'sd1, 16'sd1, 16'sd1);     // floor: -1/256 -> -1 (R3)
        strobe(-16'sd777, 16'sd1234, -16'sd99);
        idle_check();
        idle_check();
        // Random mix with gaps
        for (int i = 0; i < 400; i++) begin
            strobe(16'($urandom), 16'($urandom_range(0, 4000)), 16'($urandom_range(0, 8000)));
            if ($urandom_range(0, 3) == 0) idle_check();
        end
        // Mid-run reset (R1)
        do_reset();
        // Positive saturation (R7)
        for (int i = 0; i < 700; i++) strobe(16'sd32767, 16'sd32767, 16'sd32767);
        check("R7 max vel", vel_est, SMAX);
        check("R7 max accel", accel_est, SMAX);
        idle_check();
        // Negative saturation (R7)
        for (int i = 0; i < 1500; i++) strobe(-16'sd32768, 16'sd32767, 16'sd32767);
        check("R7 min vel", vel_est, SMIN);
        check("R7 min accel", accel_est, SMIN);
        do_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule